// File: doc/BRIEF.md
# Single-Level Page Walk Translator

This block turns a 14-bit virtual address into a 12-bit physical address for one access. When a request is taken, the block latches the address, the access type and the current table base. It forms the address of the one table entry that covers the virtual page. It then reads that 16-bit entry through a single-word memory port, holding the read request until the memory acknowledges it. The block checks the entry's valid flag and its permission flags and returns one of three results: a physical address, a page fault or a protection fault.

Pages are 64 bytes, so the low 6 address bits pass through unchanged. The upper 8 virtual bits select one of 256 entries in a table that belongs to the current process. The processor side sees a request with a ready flag and a one-cycle done pulse that carries the result. A four-state machine sequences the work:

- ST_IDLE waits for a request. Ready is high here, and a request goes to ST_FETCH.
- ST_FETCH drives the memory read. It moves to ST_CHECK on an acknowledge and otherwise stays.
- ST_CHECK evaluates the registered entry and always moves to ST_RESPOND.
- ST_RESPOND pulses done and always returns to ST_IDLE.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only in ST_IDLE. A request is accepted only on a clock edge where `req_valid` and `req_ready` are both high, and `req_valid` is ignored in every other state.
- R2: From the cycle after acceptance, `mem_req` is high and `mem_addr` equals the latched base plus twice the virtual page number (`req_vaddr[13:6]`), modulo 4096. Both hold steady until the cycle in which `mem_ack` is high.
- R3: An entry is decoded as follows. Bit 15 is valid. Bit 14 allows reads. Bit 13 allows writes. Bit 12 marks the page as supervisor-only. Bits 5:0 are the physical page number. Bits 11:6 are ignored.
- R4: If bit 15 of the entry is 0, the result is `rsp_fault` = 2'b01 (page fault) and `rsp_paddr` = 0.
- R5: A write (`req_write`=1) needs bit 13 set, and a read needs bit 14 set. A supervisor-only entry also needs `req_super`=1. If any of these is violated, the result is `rsp_fault` = 2'b10 (protection fault) and `rsp_paddr` = 0.
- R6: The valid check takes priority, so an invalid entry always gives 2'b01 whatever its permission bits say. The code 2'b11 never appears.
- R7: On success, `rsp_fault` = 2'b00 and `rsp_paddr` = {entry bits 5:0, virtual address bits 5:0}. For example, virtual address 0x0020 through entry 0x28 gives 0xA20.
- R8: `rsp_done` is high for exactly one cycle, in the second cycle after the edge that sampled `mem_ack` high. `rsp_fault` and `rsp_paddr` keep their values until the next done pulse.
- R9: Changes to `ptbr`, `req_vaddr`, `req_write` or `req_super` after acceptance do not affect the walk in progress.
- R10: After reset, `req_ready` = 1, and `mem_req`, `rsp_done`, `rsp_fault` and `rsp_paddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vaddr | input | 14 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_super | input | 1 | 1 = access made in supervisor mode |
| ptbr | input | 12 | Byte address of the current table |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 12 | Byte address of the entry |
| mem_ack | input | 1 | Memory acknowledge; data valid in the same cycle |
| mem_rdata | input | 16 | Entry word |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |
| rsp_paddr | output | 12 | Physical address, 0 on any fault |

## Verification
The assertions assume the memory acknowledges only while `mem_req` is high and delivers the entry word in that same cycle. They also assume the acknowledge is never asserted in the cycle right after acceptance by anything other than the memory responding to `mem_req`. The bench drives `mem_ack` only after it has seen `mem_req` high, raises it for exactly one cycle, and waits zero to several cycles before doing so. While a walk is under way, the bench deliberately raises `req_valid` and changes the base and the address, to show these inputs are ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_CHECK   = 2'd2,
        ST_RESPOND = 2'd3
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_PAGE = 2'b01,
        FLT_PROT = 2'b10
    } fault_code_t;

endpackage

// File: rtl/ptw_addr_split.sv
module ptw_addr_split #(
    parameter int VA_W      = 14,
    parameter int OFF_W     = 6,
    parameter int ADDR_W    = 12,
    parameter int PTE_BYTES = 2
) (
    input  logic [VA_W-1:0]   vaddr,
    input  logic [ADDR_W-1:0] base,
    output logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int SHIFT = $clog2(PTE_BYTES);

    logic [VPN_W-1:0]  vpn;
    logic [ADDR_W-1:0] scaled;

    assign vpn    = vaddr[VA_W-1:OFF_W];
    assign offset = vaddr[OFF_W-1:0];

    generate
        if (SHIFT == 0) begin : g_noscale
            assign scaled = ADDR_W'(vpn);
        end else begin : g_scale
            assign scaled = ADDR_W'({vpn, {SHIFT{1'b0}}});
        end
    endgenerate

    assign entry_addr = base + scaled;

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
#(
    parameter int PTE_W = 16,
    parameter int PPN_W = 6,
    parameter int OFF_W = 6
) (
    input  logic [PTE_W-1:0]       pte,
    input  logic                   is_write,
    input  logic                   is_super,
    input  logic [OFF_W-1:0]       offset,
    output logic [1:0]             fault,
    output logic [PPN_W+OFF_W-1:0] paddr
);
    localparam int V_POS = PTE_W - 1;
    localparam int R_POS = PTE_W - 2;
    localparam int W_POS = PTE_W - 3;
    localparam int S_POS = PTE_W - 4;

    logic type_ok;
    logic priv_ok;
    logic unused_rsvd;

    assign unused_rsvd = ^pte[S_POS-1:PPN_W];

    always_comb begin
        type_ok = is_write ? pte[W_POS] : pte[R_POS];
        priv_ok = !pte[S_POS] || is_super;
        if (!pte[V_POS]) begin
            fault = FLT_PAGE;
        end else if (!(type_ok && priv_ok)) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
        paddr = (fault == FLT_NONE) ? {pte[PPN_W-1:0], offset} : '0;
    end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic mem_ack,
    output logic req_ready,
    output logic mem_req,
    output logic load_req,
    output logic load_pte,
    output logic load_rsp,
    output logic rsp_done
);
    walk_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nx = ST_FETCH;
            ST_FETCH:   if (mem_ack)   state_nx = ST_CHECK;
            ST_CHECK:   state_nx = ST_RESPOND;
            ST_RESPOND: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        load_req  = 1'b0;
        load_pte  = 1'b0;
        load_rsp  = 1'b0;
        rsp_done  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                load_req  = req_valid;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                load_pte = mem_ack;
            end
            ST_CHECK:   load_rsp = 1'b1;
            ST_RESPOND: rsp_done = 1'b1;
        endcase
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int VA_W       = 14,
    parameter int PA_W       = 12,
    parameter int PAGE_BYTES = 64,
    parameter int PTE_W      = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    input  logic            req_super,
    input  logic [PA_W-1:0] ptbr,
    output logic            mem_req,
    output logic [PA_W-1:0] mem_addr,
    input  logic            mem_ack,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic            rsp_done,
    output logic [1:0]      rsp_fault,
    output logic [PA_W-1:0] rsp_paddr
);
    localparam int OFF_W     = $clog2(PAGE_BYTES);
    localparam int PPN_W     = PA_W - OFF_W;
    localparam int PTE_BYTES = PTE_W / 8;

    logic             load_req, load_pte, load_rsp;
    logic [OFF_W-1:0] offset_c;
    logic [PA_W-1:0]  entry_addr_c;
    logic [1:0]       fault_c;
    logic [PA_W-1:0]  paddr_c;

    logic [PA_W-1:0]  entry_addr_q;
    logic [OFF_W-1:0] offset_q;
    logic             is_write_q, is_super_q;
    logic [PTE_W-1:0] pte_q;
    logic [1:0]       fault_q;
    logic [PA_W-1:0]  paddr_q;

    ptw_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .mem_ack   (mem_ack),
        .req_ready (req_ready),
        .mem_req   (mem_req),
        .load_req  (load_req),
        .load_pte  (load_pte),
        .load_rsp  (load_rsp),
        .rsp_done  (rsp_done)
    );

    ptw_addr_split #(
        .VA_W      (VA_W),
        .OFF_W     (OFF_W),
        .ADDR_W    (PA_W),
        .PTE_BYTES (PTE_BYTES)
    ) u_split (
        .vaddr      (req_vaddr),
        .base       (ptbr),
        .offset     (offset_c),
        .entry_addr (entry_addr_c)
    );

    ptw_pte_check #(
        .PTE_W (PTE_W),
        .PPN_W (PPN_W),
        .OFF_W (OFF_W)
    ) u_check (
        .pte      (pte_q),
        .is_write (is_write_q),
        .is_super (is_super_q),
        .offset   (offset_q),
        .fault    (fault_c),
        .paddr    (paddr_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_addr_q <= '0;
            offset_q     <= '0;
            is_write_q   <= 1'b0;
            is_super_q   <= 1'b0;
            pte_q        <= '0;
            fault_q      <= '0;
            paddr_q      <= '0;
        end else begin
            if (load_req) begin
                entry_addr_q <= entry_addr_c;
                offset_q     <= offset_c;
                is_write_q   <= req_write;
                is_super_q   <= req_super;
            end
            if (load_pte) begin
                pte_q <= mem_rdata;
            end
            if (load_rsp) begin
                fault_q <= fault_c;
                paddr_q <= paddr_c;
            end
        end
    end

    assign mem_addr  = entry_addr_q;
    assign rsp_fault = fault_q;
    assign rsp_paddr = paddr_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rsp_done,
    input logic [1:0]        rsp_fault,
    input logic [ADDR_W-1:0] rsp_paddr
);
    assert_ready_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req && !rsp_done);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    assert_fault_zero_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done && rsp_fault != 2'b00 |-> rsp_paddr == '0);

    assert_legal_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> rsp_fault != 2'b11);

    assert_ack_to_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !rsp_done ##1 rsp_done);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done && req_ready);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> $stable(rsp_fault) && $stable(rsp_paddr));

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .rsp_done  (rsp_done),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_super = 1'b0;
    logic [11:0] ptbr = '0;
    logic        mem_req;
    logic [11:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        rsp_done;
    logic [1:0]  rsp_fault;
    logic [11:0] rsp_paddr;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;
    logic [1:0]  last_fault;
    logic [11:0] last_paddr;
    logic [15:0] bmem [0:4095];

    always #4 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_super(req_super),
        .ptbr(ptbr), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Entry layout per R3: [15] valid, [14] read, [13] write, [12] sup-only, [5:0] page
    function automatic logic [15:0] table_pte(input int vpn);
        logic [5:0] pg;
        logic       v;
        logic [2:0] pm;
        case (vpn)
            'h00: pg = 6'h28;  'h02: pg = 6'h33;  'h03: pg = 6'h02;
            'h05: pg = 6'h16;  'h08: pg = 6'h13;  'h09: pg = 6'h17;
            'h0A: pg = 6'h09;  'h0D: pg = 6'h2D;  'h0E: pg = 6'h11;
            'h0F: pg = 6'h0D;  default: pg = 6'h3F;
        endcase
        if (vpn < 16) begin
            v  = (pg != 6'h3F);
            pm = v ? 3'b110 : 3'b000;
        end else begin
            v  = (vpn % 3 != 0) && (vpn != 'h2E);
            pm = 3'(vpn >> 4) ^ 3'(vpn);
            pg = 6'((vpn * 7 + 3) & 63);
        end
        return {v, pm, 6'h15, pg};
    endfunction

    function automatic logic [1:0] exp_fault(input logic [15:0] e, input logic wr, input logic su);
        if (!e[15]) return 2'b01;
        if ((wr ? !e[13] : !e[14]) || (e[12] && !su)) return 2'b10;
        return 2'b00;
    endfunction

    task automatic load_table(input logic [11:0] base);
        for (int v = 0; v < 256; v++) bmem[12'(base + 12'(v * 2))] = table_pte(v);
    endtask

    task automatic run_one(input logic [13:0] va, input logic wr, input logic su,
                           input int dly, input bit poke);
        logic [11:0] base;
        logic [11:0] eaddr;
        logic [15:0] e;
        logic [1:0]  ef;
        logic [11:0] ep;
        base  = ptbr;
        eaddr = base + {3'b000, va[13:6], 1'b0};
        e     = bmem[eaddr];
        ef    = exp_fault(e, wr, su);
        ep    = (ef == 2'b00) ? {e[5:0], va[5:0]} : 12'h000;
        chk(req_ready == 1'b1, "R1 ready in idle", 32'(req_ready), 1);
        req_vaddr = va; req_write = wr; req_super = su; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk(mem_req == 1'b1 && req_ready == 1'b0, "R1 busy after accept", {mem_req, req_ready}, 32'b10);
        chk(mem_addr == eaddr, "R2 entry address", 32'(mem_addr), 32'(eaddr));
        if (poke) begin
            req_valid = 1'b1; req_vaddr = ~va; req_write = ~wr; req_super = ~su;
            ptbr = base + 12'h040;
        end
        for (int i = 0; i < dly; i++) begin
            @(posedge clk); @(negedge clk);
            chk(mem_req == 1'b1 && mem_addr == eaddr, "R2 request held", 32'(mem_addr), 32'(eaddr));
        end
        mem_ack = 1'b1; mem_rdata = e;
        @(posedge clk); @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 16'hFFFF;
        chk(rsp_done == 1'b0, "R8 no early done", 32'(rsp_done), 0);
        @(posedge clk); @(negedge clk);
        chk(rsp_done == 1'b1, "R8 done timing", 32'(rsp_done), 1);
        chk(rsp_fault == ef, poke ? "R9 fault under poke" : "R4 R5 R6 fault code", 32'(rsp_fault), 32'(ef));
        chk(rsp_paddr == ep, poke ? "R9 paddr under poke" : "R7 physical address", 32'(rsp_paddr), 32'(ep));
        last_fault = rsp_fault; last_paddr = rsp_paddr;
        if (poke) begin
            req_valid = 1'b0; ptbr = base;
        end
        @(posedge clk); @(negedge clk);
        chk(rsp_done == 1'b0 && rsp_fault == ef && rsp_paddr == ep, "R8 pulse and hold",
            {rsp_done, rsp_fault, rsp_paddr}, {1'b0, ef, ep});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && mem_req == 1'b0 && rsp_done == 1'b0, "R10 reset handshake",
            {req_ready, mem_req, rsp_done}, 32'b100);
        chk(rsp_fault == 2'b00 && rsp_paddr == 12'h000, "R10 reset result", {rsp_fault, rsp_paddr}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        ptbr = 12'h100;
        load_table(ptbr);
        run_one(14'h0020, 1'b0, 1'b0, 0, 1'b0);
        chk(last_fault == 2'b00 && last_paddr == 12'hA20, "R7 vector 0x0020",
            {last_fault, last_paddr}, 32'h0A20);
        run_one(14'h0B8F, 1'b0, 1'b0, 1, 1'b0);
        chk(last_fault == 2'b01 && last_paddr == 12'h000, "R4 vector 0x0B8F",
            {last_fault, last_paddr}, 32'h1000);
        run_one(14'h0040, 1'b1, 1'b1, 0, 1'b0);
        chk(last_fault == 2'b01, "R6 invalid beats permission", 32'(last_fault), 1);

        // full sweep of pages and access kinds, two bases, varying ack delay
        for (int pass = 0; pass < 2; pass++) begin
            ptbr = (pass == 0) ? 12'h100 : 12'h600;
            load_table(ptbr);
            for (int v = 0; v < 256; v++) begin
                for (int k = 0; k < 4; k++) begin
                    run_one({8'(v), 6'((v * 5 + k * 11) & 63)}, k[0], k[1],
                            (pass == 0) ? 0 : (v % 3), 1'b0);
                end
            end
        end

        // ignored inputs during a walk (R9, R1)
        ptbr = 12'h100;
        load_table(ptbr);
        run_one(14'h03D4, 1'b0, 1'b0, 2, 1'b1);
        run_one(14'h1234, 1'b1, 1'b0, 0, 1'b1);
        run_one(14'h2A7F, 1'b0, 1'b1, 3, 1'b1);

        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
        $finish;
    end
endmodule